// File: doc/BRIEF.md
# Strided Scratchpad Page Mover

This block moves bulk data between an on-chip scratchpad and off-chip memory on behalf of software. A single command names a direction, a scratchpad base word, an off-chip base word, a block length in words, a stride in words and a block count. The engine then walks the off-chip side block by block, stepping the stride between block starts. The words that lie between blocks are never requested. On the scratchpad side the blocks are packed back to back.

A page-load gathers strided off-chip blocks into a dense scratchpad region. A page-store scatters a dense scratchpad region out to strided off-chip blocks. Only one command is in flight at a time. The command port accepts work only while the engine is idle, and a one-cycle done pulse marks completion. The off-chip port is a request/grant interface with read data returned later on a valid strobe. The scratchpad port is a synchronous single-port memory interface with one cycle of read latency.

Top module: `stride_xfer_engine`

## Requirements
- R1: With cmd_dir = 0 (load), every word read from off-chip address A is written to the scratchpad unchanged, in ascending order of (block, word).
- R2: With cmd_dir = 1 (store), every scratchpad word read is written to off-chip memory unchanged, in ascending order of (block, word). Scratchpad read data is taken in the cycle after sp_re.
- R3: The off-chip address for word j of block i is off_base + i*stride + j, modulo 2^OFF_AW. No other off-chip address is requested, so inter-block gaps are never touched.
- R4: The scratchpad address for word j of block i is sp_base + i*blk_len + j, modulo 2^SP_AW.
- R5: cmd_ready is high exactly when the engine is idle. A cmd_valid raised while busy is ignored. While idle, no memory strobe is active.
- R6: done is high for exactly one cycle. For a load it follows the cycle of the final scratchpad write, and for a store it follows the cycle in which the final off-chip write is granted.
- R7: A command with block length 0 or block count 0 raises done in the cycle after acceptance and makes no memory access.
- R8: While mem_req is high and mem_gnt low, mem_req, mem_addr, mem_we and mem_wdata hold their values into the next cycle.
- R9: A stride of 0 re-reads the same block for each count. Stride values smaller than the block length are legal, and off-chip addresses wrap at the address width.
- R10: At most one off-chip read is outstanding: after a read grant, mem_req stays low until mem_rvalid. sp_we and sp_re are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken when valid |
| cmd_dir | input | 1 | 0 = load (off-chip to scratchpad), 1 = store |
| cmd_sp_base | input | SP_AW | Scratchpad start word |
| cmd_off_base | input | OFF_AW | Off-chip start word |
| cmd_blk_len | input | LEN_W | Words per block |
| cmd_stride | input | OFF_AW | Words between block starts |
| cmd_blk_cnt | input | CNT_W | Number of blocks |
| mem_req | output | 1 | Off-chip request |
| mem_we | output | 1 | Off-chip request is a write |
| mem_addr | output | OFF_AW | Off-chip word address |
| mem_wdata | output | DATA_W | Off-chip write data |
| mem_gnt | input | 1 | Off-chip request accepted this cycle |
| mem_rvalid | input | 1 | Off-chip read data valid |
| mem_rdata | input | DATA_W | Off-chip read data |
| sp_we | output | 1 | Scratchpad write strobe |
| sp_re | output | 1 | Scratchpad read strobe |
| sp_addr | output | SP_AW | Scratchpad word address |
| sp_wdata | output | DATA_W | Scratchpad write data |
| sp_rdata | input | DATA_W | Scratchpad read data, valid the cycle after sp_re |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets block boundaries, a zero stride, an off-chip base near the top of the address space, and single-word blocks. A design that got the row advance wrong would request gap words or repeat the wrong block, and the scoreboard would see an unexpected address. Zero length and zero count commands are issued in both directions. An engine that ignored the zero rule would touch memory or hang without done. Random grant backpressure and variable read latency expose a design that drops held write data or issues a second read early. A command poked in mid-transfer would show up as extra accesses if the busy guard were missing. A done raised one cycle early or late is caught against the cycle of the final write.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [2:0] {
    XS_IDLE    = 3'd0,
    XS_RD_REQ  = 3'd1,
    XS_RD_WAIT = 3'd2,
    XS_SP_RD   = 3'd3,
    XS_SP_LAT  = 3'd4,
    XS_WR_REQ  = 3'd5,
    XS_FIN     = 3'd6
  } xfer_state_e;

  localparam logic DIR_LOAD  = 1'b0;
  localparam logic DIR_STORE = 1'b1;
endpackage

// File: rtl/xfer_addr_gen.sv
module xfer_addr_gen #(
  parameter int SP_AW  = 10,
  parameter int OFF_AW = 16,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [SP_AW-1:0]  sp_base,
  input  logic [OFF_AW-1:0] off_base,
  input  logic [LEN_W-1:0]  blk_len,
  input  logic [OFF_AW-1:0] stride,
  input  logic [CNT_W-1:0]  blk_cnt,
  output logic [SP_AW-1:0]  sp_addr,
  output logic [OFF_AW-1:0] off_addr,
  output logic              last
);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [LEN_W-1:0]  len_q, j_q, j_d;
  logic [CNT_W-1:0]  cnt_q, i_q, i_d;
  logic [OFF_AW-1:0] stride_q, row_q, row_d, off_q, off_d;
  logic [SP_AW-1:0]  sp_q, sp_d;
  logic              blk_end, upd;

  assign blk_end = (j_q == len_q - LEN_ONE);
  assign last    = blk_end && (i_q == cnt_q - CNT_ONE);
  assign upd     = load || step;

  always_comb begin
    if (load) begin
      j_d   = '0;
      i_d   = '0;
      row_d = off_base;
      off_d = off_base;
      sp_d  = sp_base;
    end else if (blk_end) begin
      j_d   = '0;
      i_d   = i_q + CNT_ONE;
      row_d = row_q + stride_q;
      off_d = row_q + stride_q;
      sp_d  = sp_q + SP_AW'(1);
    end else begin
      j_d   = j_q + LEN_ONE;
      i_d   = i_q;
      row_d = row_q;
      off_d = off_q + OFF_AW'(1);
      sp_d  = sp_q + SP_AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q    <= '0;
      cnt_q    <= '0;
      stride_q <= '0;
    end else if (load) begin
      len_q    <= blk_len;
      cnt_q    <= blk_cnt;
      stride_q <= stride;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      j_q   <= '0;
      i_q   <= '0;
      row_q <= '0;
      off_q <= '0;
      sp_q  <= '0;
    end else if (upd) begin
      j_q   <= j_d;
      i_q   <= i_d;
      row_q <= row_d;
      off_q <= off_d;
      sp_q  <= sp_d;
    end
  end

  assign sp_addr  = sp_q;
  assign off_addr = off_q;
endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_dir,
  input  logic cmd_zero,
  input  logic mem_gnt,
  input  logic mem_rvalid,
  input  logic last,
  output logic cmd_ready,
  output logic accept,
  output logic step,
  output logic mem_req,
  output logic mem_we,
  output logic sp_we,
  output logic sp_re,
  output logic cap_en,
  output logic done
);
  xfer_state_e st_q, st_d;

  assign cmd_ready = (st_q == XS_IDLE);
  assign accept    = cmd_ready && cmd_valid;
  assign mem_req   = (st_q == XS_RD_REQ) || (st_q == XS_WR_REQ);
  assign mem_we    = (st_q == XS_WR_REQ);
  assign sp_we     = (st_q == XS_RD_WAIT) && mem_rvalid;
  assign sp_re     = (st_q == XS_SP_RD);
  assign cap_en    = (st_q == XS_SP_LAT);
  assign done      = (st_q == XS_FIN);
  assign step      = sp_we || ((st_q == XS_WR_REQ) && mem_gnt);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      XS_IDLE: begin
        if (cmd_valid) begin
          if (cmd_zero)                st_d = XS_FIN;
          else if (cmd_dir == DIR_LOAD) st_d = XS_RD_REQ;
          else                         st_d = XS_SP_RD;
        end
      end
      XS_RD_REQ:  if (mem_gnt) st_d = XS_RD_WAIT;
      XS_RD_WAIT: if (mem_rvalid) st_d = last ? XS_FIN : XS_RD_REQ;
      XS_SP_RD:   st_d = XS_SP_LAT;
      XS_SP_LAT:  st_d = XS_WR_REQ;
      XS_WR_REQ:  if (mem_gnt) st_d = last ? XS_FIN : XS_SP_RD;
      XS_FIN:     st_d = XS_IDLE;
      default:    st_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= XS_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/stride_xfer_engine.sv
module stride_xfer_engine #(
  parameter int DATA_W = 32,
  parameter int SP_AW  = 10,
  parameter int OFF_AW = 16,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_dir,
  input  logic [SP_AW-1:0]  cmd_sp_base,
  input  logic [OFF_AW-1:0] cmd_off_base,
  input  logic [LEN_W-1:0]  cmd_blk_len,
  input  logic [OFF_AW-1:0] cmd_stride,
  input  logic [CNT_W-1:0]  cmd_blk_cnt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [OFF_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              sp_we,
  output logic              sp_re,
  output logic [SP_AW-1:0]  sp_addr,
  output logic [DATA_W-1:0] sp_wdata,
  input  logic [DATA_W-1:0] sp_rdata,
  output logic              done
);
  logic accept, step, cap_en, last, cmd_zero;
  logic [DATA_W-1:0] wbuf_q;

  assign cmd_zero = (cmd_blk_len == '0) || (cmd_blk_cnt == '0);

  xfer_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_dir    (cmd_dir),
    .cmd_zero   (cmd_zero),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .last       (last),
    .cmd_ready  (cmd_ready),
    .accept     (accept),
    .step       (step),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .sp_we      (sp_we),
    .sp_re      (sp_re),
    .cap_en     (cap_en),
    .done       (done)
  );

  xfer_addr_gen #(
    .SP_AW  (SP_AW),
    .OFF_AW (OFF_AW),
    .LEN_W  (LEN_W),
    .CNT_W  (CNT_W)
  ) u_agen (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .step     (step),
    .sp_base  (cmd_sp_base),
    .off_base (cmd_off_base),
    .blk_len  (cmd_blk_len),
    .stride   (cmd_stride),
    .blk_cnt  (cmd_blk_cnt),
    .sp_addr  (sp_addr),
    .off_addr (mem_addr),
    .last     (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wbuf_q <= '0;
    else if (cap_en) wbuf_q <= sp_rdata;
  end

  assign mem_wdata = wbuf_q;
  assign sp_wdata  = mem_rdata;
endmodule

// File: rtl/xfer_checker.sv
module xfer_checker #(
  parameter int DATA_W = 32,
  parameter int OFF_AW = 16,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [LEN_W-1:0]  cmd_blk_len,
  input logic [CNT_W-1:0]  cmd_blk_cnt,
  input logic              mem_req,
  input logic              mem_we,
  input logic [OFF_AW-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_gnt,
  input logic              mem_rvalid,
  input logic              sp_we,
  input logic              sp_re,
  input logic              done
);
  logic rd_out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           rd_out_q <= 1'b0;
    else if (mem_req && mem_gnt && !mem_we) rd_out_q <= 1'b1;
    else if (mem_rvalid)                  rd_out_q <= 1'b0;
  end

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!mem_req && !sp_we && !sp_re && !done));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_blk_len == '0 || cmd_blk_cnt == '0)) |=> done);

  a_r8_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r10_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out_q |-> !mem_req);

  a_r10_sp_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(sp_we && sp_re));
endmodule

bind stride_xfer_engine xfer_checker #(
  .DATA_W (DATA_W),
  .OFF_AW (OFF_AW),
  .LEN_W  (LEN_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_blk_len (cmd_blk_len),
  .cmd_blk_cnt (cmd_blk_cnt),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_gnt     (mem_gnt),
  .mem_rvalid  (mem_rvalid),
  .sp_we       (sp_we),
  .sp_re       (sp_re),
  .done        (done)
);

// File: tb/tb_stride_xfer_engine.sv
module tb_stride_xfer_engine;
  localparam int DATA_W = 32;
  localparam int SP_AW  = 10;
  localparam int OFF_AW = 16;
  localparam int LEN_W  = 8;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_dir = 1'b0;
  logic cmd_ready;
  logic [SP_AW-1:0]  cmd_sp_base = '0;
  logic [OFF_AW-1:0] cmd_off_base = '0, cmd_stride = '0;
  logic [LEN_W-1:0]  cmd_blk_len = '0;
  logic [CNT_W-1:0]  cmd_blk_cnt = '0;
  logic mem_req, mem_we, sp_we, sp_re, done;
  logic [OFF_AW-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, sp_wdata;
  logic [SP_AW-1:0]  sp_addr;
  logic mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0, sp_rdata = '0;

  always #10 clk = ~clk;

  stride_xfer_engine #(.DATA_W(DATA_W), .SP_AW(SP_AW), .OFF_AW(OFF_AW),
                       .LEN_W(LEN_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dir(cmd_dir), .cmd_sp_base(cmd_sp_base), .cmd_off_base(cmd_off_base),
    .cmd_blk_len(cmd_blk_len), .cmd_stride(cmd_stride), .cmd_blk_cnt(cmd_blk_cnt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .sp_we(sp_we), .sp_re(sp_re), .sp_addr(sp_addr), .sp_wdata(sp_wdata),
    .sp_rdata(sp_rdata), .done(done));

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [DATA_W-1:0] sp_mem [0:(1<<SP_AW)-1];
  logic [OFF_AW-1:0] exp_rd_q [$];
  logic [OFF_AW+DATA_W-1:0] exp_wr_q [$];
  logic [SP_AW+DATA_W-1:0]  exp_sp_q [$];

  logic bp_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int rd_cd = 0;
  logic [OFF_AW-1:0] rd_pend = '0;
  logic rd_busy = 1'b0;
  int done_cnt = 0, done_cyc = 0, last_evt_cyc = -10, evt_cnt = 0;
  logic held = 1'b0;
  logic [OFF_AW-1:0] h_addr;
  logic h_we;
  logic [DATA_W-1:0] h_wdata;

  function automatic logic [DATA_W-1:0] off_val(input logic [OFF_AW-1:0] a);
    return {a ^ 16'h5A3C, a};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // off-chip and scratchpad models plus monitor
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_gnt = mem_req && (!bp_on || lfsr[0]);
      if (rd_cd > 0) begin
        rd_cd--;
        mem_rvalid = (rd_cd == 0);
        if (rd_cd == 0) begin
          mem_rdata = off_val(rd_pend);
          rd_busy = 1'b0;
        end
      end else mem_rvalid = 1'b0;
      if (sp_re) sp_rdata = sp_mem[sp_addr];
      #5;
      if (held) begin
        chk(mem_req && mem_addr == h_addr && mem_we == h_we && mem_wdata == h_wdata,
            "R8", "held request changed", {mem_we, mem_addr, mem_wdata}, {h_we, h_addr, h_wdata});
        held = 1'b0;
      end
      if (mem_req && rd_busy && !mem_rvalid)
        chk(1'b0, "R10", "request with read outstanding", 64'(mem_addr), 0);
      if (mem_req && !mem_gnt) begin
        held = 1'b1; h_addr = mem_addr; h_we = mem_we; h_wdata = mem_wdata;
      end
      if (mem_req && mem_gnt && !mem_we) begin
        evt_cnt++;
        if (exp_rd_q.size() == 0) chk(1'b0, "R3", "unexpected read", 64'(mem_addr), 0);
        else begin
          logic [OFF_AW-1:0] e;
          e = exp_rd_q.pop_front();
          chk(mem_addr == e, "R3", "read address", 64'(mem_addr), 64'(e));
        end
        rd_pend = mem_addr; rd_busy = 1'b1;
        rd_cd = 1 + int'(lfsr[2:1] % 3);
      end
      if (mem_req && mem_gnt && mem_we) begin
        evt_cnt++; last_evt_cyc = cyc;
        if (exp_wr_q.size() == 0) chk(1'b0, "R2", "unexpected write", 64'(mem_addr), 0);
        else begin
          logic [OFF_AW+DATA_W-1:0] e;
          e = exp_wr_q.pop_front();
          chk({mem_addr, mem_wdata} == e, "R2", "off-chip write addr/data",
              64'({mem_addr, mem_wdata}), 64'(e));
        end
      end
      if (sp_we && sp_re) chk(1'b0, "R10", "sp we and re together", 1, 0);
      if (sp_we) begin
        evt_cnt++; last_evt_cyc = cyc;
        if (exp_sp_q.size() == 0) chk(1'b0, "R1", "unexpected sp write", 64'(sp_addr), 0);
        else begin
          logic [SP_AW+DATA_W-1:0] e;
          e = exp_sp_q.pop_front();
          chk({sp_addr, sp_wdata} == e, "R4", "sp write addr/data",
              64'({sp_addr, sp_wdata}), 64'(e));
        end
        sp_mem[sp_addr] = sp_wdata;
      end
      if (sp_re) evt_cnt++;
      if (done) begin done_cnt++; done_cyc = cyc; end
    end
  end

  // driver: pushes expectations, issues command, waits for done
  task automatic run_cmd(input logic dir, input int spb, input int offb, input int len,
                         input int stride, input int cnt, input logic bp, input logic poke,
                         input string req);
    int d0, e0, acc_cyc, wd;
    bit zero;
    zero = (len == 0) || (cnt == 0);
    for (int i = 0; i < cnt; i++)
      for (int j = 0; j < len; j++) begin
        logic [OFF_AW-1:0] oa;
        logic [SP_AW-1:0] sa;
        oa = OFF_AW'(offb + i*stride + j);
        sa = SP_AW'(spb + i*len + j);
        if (dir == 1'b0) begin
          exp_rd_q.push_back(oa);
          exp_sp_q.push_back({sa, off_val(oa)});
        end else exp_wr_q.push_back({oa, sp_mem[sa]});
      end
    bp_on = bp;
    @(negedge clk);
    chk(cmd_ready, "R5", "ready while idle", 64'(cmd_ready), 1);
    cmd_dir = dir; cmd_sp_base = SP_AW'(spb); cmd_off_base = OFF_AW'(offb);
    cmd_blk_len = LEN_W'(len); cmd_stride = OFF_AW'(stride); cmd_blk_cnt = CNT_W'(cnt);
    cmd_valid = 1'b1;
    d0 = done_cnt; e0 = evt_cnt;
    @(negedge clk);
    acc_cyc = cyc;
    cmd_valid = 1'b0;
    if (poke) begin
      @(negedge clk); @(negedge clk);
      chk(!cmd_ready, "R5", "ready low while busy", 64'(cmd_ready), 0);
      cmd_dir = ~dir; cmd_blk_len = 8'd3; cmd_blk_cnt = 8'd2; cmd_off_base = 16'h7777;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    wd = 0;
    while (done_cnt == d0 && wd < 3000) begin @(negedge clk); wd++; end
    if (wd >= 3000) chk(1'b0, req, "watchdog: no done", 0, 1);
    @(negedge clk); @(negedge clk);
    chk(done_cnt == d0 + 1, "R6", "single done pulse", 64'(done_cnt - d0), 1);
    if (zero) begin
      chk(done_cyc == acc_cyc, "R7", "zero command done cycle", 64'(done_cyc), 64'(acc_cyc));
      chk(evt_cnt == e0, "R7", "zero command memory accesses", 64'(evt_cnt - e0), 0);
    end else begin
      chk(done_cyc == last_evt_cyc + 1, "R6", "done after final write",
          64'(done_cyc), 64'(last_evt_cyc + 1));
    end
    chk(exp_rd_q.size() == 0 && exp_wr_q.size() == 0 && exp_sp_q.size() == 0, req,
        "expected accesses left over",
        64'(exp_rd_q.size() + exp_wr_q.size() + exp_sp_q.size()), 0);
  endtask

  initial begin
    for (int k = 0; k < (1 << SP_AW); k++) sp_mem[k] = 32'hC000_0000 | 32'(k * 7);
    #35;
    chk(cmd_ready == 1'b1 && !mem_req && !sp_we && !sp_re && !done, "R5",
        "reset state", {59'd0, cmd_ready, mem_req, sp_we, sp_re, done}, 5'b10000);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 R3 R4: strided gather, gaps skipped
    run_cmd(1'b0, 'h20, 'h100, 3, 8, 4, 1'b0, 1'b0, "R1");
    // R2: scatter with backpressure and busy poke (R5, R8)
    run_cmd(1'b1, 'h40, 'h2000, 5, 9, 3, 1'b1, 1'b1, "R2");
    // R9: stride zero re-reads the same block
    run_cmd(1'b0, 'h80, 'h300, 2, 0, 3, 1'b1, 1'b0, "R9");
    // R7: zero length, zero count
    run_cmd(1'b0, 'h10, 'h500, 0, 4, 5, 1'b0, 1'b0, "R7");
    run_cmd(1'b1, 'h10, 'h500, 4, 4, 0, 1'b0, 1'b0, "R7");
    // R9: address wrap with single-word blocks
    run_cmd(1'b0, 'h3F8, 'hF000, 1, 'h4000, 6, 1'b1, 1'b0, "R9");
    // R2: contiguous store (stride == length), stores scratchpad just loaded
    run_cmd(1'b1, 'h20, 'h9000, 12, 12, 1, 1'b1, 1'b1, "R2");
    // R3: overlapping stride smaller than length
    run_cmd(1'b0, 'h200, 'h40, 4, 2, 3, 1'b1, 1'b0, "R3");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule